// File: doc/BRIEF.md
# Burst-Synchronized Codec Clock Sequencer

This block lives at the remote end of a two-wire digital subscriber loop. It divides a 4.096 MHz reference by 32 to get a 128 kHz data clock for a local voice codec. The clock is not free-running. Each time the line demodulator reports that a burst from the far end has been fully received, the block emits a train of exactly sixteen clock periods and then parks the clock low. Because the local timing restarts on every received burst, any drift between the two ends is absorbed once per frame.

During the first eight periods of a train, the transmit enable is high. In that window the block shifts an 8-bit voice word to the codec, most significant bit first, and its data output is enabled. During the last eight periods, the receive enable (always the inverse of the transmit enable) is high, and the block captures eight bits coming back from the codec.

A test/tone input makes the block generate back-to-back trains from the reference alone. A loopback-control input, when held low, silences the clock pin.

Top module: `burst_codec_clk`

## Requirements
- R1: A synchronous active-low reset makes the following hold in the cycle after the reset edge: `cdc_clk` = 0, `tx_en` = 0, `tx_oe` = 0, `rx_en` = 1, `rx_valid` = 0 and `rx_word` = 0. A reset in the middle of a train aborts that train.
- R2: When idle, an end-of-burst pulse sampled at a clock edge starts a train at that same edge. Number the state after that edge as index 0. At index k of the train, `cdc_clk` is high when (k mod 32) < 16.
- R3: A train lasts exactly 512 reference cycles (16 clock periods). From index 512 onward, `cdc_clk` stays 0 and `tx_en` stays 0 until the next trigger.
- R4: `tx_en` and `tx_oe` are high during periods 0..7 of a train (period p = k/32) and low at all other times. `rx_en` is always the inverse of `tx_en`, including while idle.
- R5: In period p (0..7), `tx_data` carries bit (7-p) of the `tx_word` value captured when the train starts. `tx_data` is 0 while `tx_oe` is low.
- R6: In periods 8..15, `rx_data` is sampled at index p*32+15, which is the last cycle before the clock falls. Bits are taken MSB first. `rx_word` is updated and `rx_valid` pulses for one cycle at index 496.
- R7: An end-of-burst pulse that arrives during a train restarts the train at the next period boundary. The index returns to 0 right after phase 31 of the current period, and `tx_word` is captured again at that point.
- R8: While `free_run` is high, trains start without a trigger and repeat back to back with no gap. When `free_run` falls, the current train completes and the clock then parks.
- R9: An end-of-burst pulse while `free_run` is high restarts the train as in R7. Free-run is then suspended, so the clock parks after that train, until `free_run` goes low.
- R10: While `loop_n` is low, `cdc_clk` is held at 0. The enables, data and capture keep their normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_done | input | 1 | One-cycle pulse: far-end burst fully demodulated |
| free_run | input | 1 | High: generate trains from the reference alone |
| loop_n | input | 1 | Low: hold the codec clock output at 0 |
| tx_word | input | 8 | Voice word to send to the codec, captured at train start |
| rx_data | input | 1 | Serial voice data from the codec |
| cdc_clk | output | 1 | Gated 128 kHz codec data clock |
| tx_en | output | 1 | Transmit window enable |
| rx_en | output | 1 | Receive window enable, inverse of tx_en |
| tx_data | output | 1 | Serial voice data to the codec |
| tx_oe | output | 1 | Output enable for tx_data (stands in for tri-state) |
| rx_word | output | 8 | Last captured 8-bit word from the codec |
| rx_valid | output | 1 | One-cycle pulse when rx_word is updated |

## Verification
A trigger or a free-run request sampled at edge E shows up on the outputs in the state right after E, which is index 0. Each later result is due a fixed number of reference cycles after that: clock edges every 16 cycles, the enable swap at index 256, the end of the train at index 512, and the captured word at index 496. For each index, the bench computes what every output should be from these offsets. It drives inputs and compares outputs on the falling edge of the reference, so each comparison sees the state that settled after the preceding rising edge. For a mid-train restart, the bench moves its index base to the boundary that follows the pulse, and checks the old train before that boundary and the new train after it.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    // reference cycles per codec clock period
    parameter int unsigned REF_DIV  = 32;
    // codec clock periods per train
    parameter int unsigned PERIODS  = 16;

    localparam int unsigned PH_W     = $clog2(REF_DIV);
    localparam int unsigned PER_W    = $clog2(PERIODS);
    localparam int unsigned WORD_W   = PERIODS / 2;
    localparam int unsigned HALF_DIV = REF_DIV / 2;

    typedef struct packed {
        logic             active;
        logic             pend;
        logic             blk;
        logic [PH_W-1:0]  phase;
        logic [PER_W-1:0] period;
    } timer_t;

    typedef struct packed {
        logic [WORD_W-1:0] sh;
    } txs_t;

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] word;
        logic              valid;
    } rxs_t;
endpackage

// File: rtl/bcs_timer.sv
module bcs_timer
    import bcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_done,
    input  logic             free_run,
    output logic             active_o,
    output logic [PH_W-1:0]  phase_o,
    output logic [PER_W-1:0] period_o,
    output logic             load_o,
    output logic             shift_o
);
    timer_t s_q, s_d;
    logic   boundary, last, fr_en, start;

    always_comb begin
        boundary = s_q.active && (s_q.phase == PH_W'(REF_DIV - 1));
        last     = boundary && (s_q.period == PER_W'(PERIODS - 1));
        fr_en    = free_run && !s_q.blk;
        start    = (!s_q.active && (burst_done || fr_en))
                 || (boundary && (s_q.pend || burst_done))
                 || (last && fr_en);

        s_d     = s_q;
        s_d.blk = free_run && (s_q.blk || burst_done);
        if (start) begin
            s_d.active = 1'b1;
            s_d.pend   = 1'b0;
            s_d.phase  = '0;
            s_d.period = '0;
        end else if (s_q.active) begin
            s_d.pend = s_q.pend || burst_done;
            if (boundary) begin
                s_d.phase  = '0;
                s_d.period = s_q.period + 1'b1;
                if (last) begin
                    s_d.active = 1'b0;
                end
            end else begin
                s_d.phase = s_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o = s_q.active;
    assign phase_o  = s_q.phase;
    assign period_o = s_q.period;
    assign load_o   = start;
    assign shift_o  = boundary && !start;
endmodule

// File: rtl/bcs_tx_shift.sv
module bcs_tx_shift
    import bcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] word_i,
    output logic              msb_o
);
    txs_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.sh = word_i;
        end else if (shift) begin
            s_d.sh = {s_q.sh[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign msb_o = s_q.sh[WORD_W-1];
endmodule

// File: rtl/bcs_rx_shift.sv
module bcs_rx_shift
    import bcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              last,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);
    rxs_t s_q, s_d;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (sample) begin
            s_d.sh = {s_q.sh[WORD_W-2:0], bit_i};
            if (last) begin
                s_d.word  = {s_q.sh[WORD_W-2:0], bit_i};
                s_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o  = s_q.word;
    assign valid_o = s_q.valid;
endmodule

// File: rtl/burst_codec_clk.sv
module burst_codec_clk
    import bcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_done,
    input  logic              free_run,
    input  logic              loop_n,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              rx_data,
    output logic              cdc_clk,
    output logic              tx_en,
    output logic              rx_en,
    output logic              tx_data,
    output logic              tx_oe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    logic             active, load, shift, msb;
    logic [PH_W-1:0]  phase;
    logic [PER_W-1:0] period;
    logic             sample, last_per;

    bcs_timer u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_done (burst_done),
        .free_run   (free_run),
        .active_o   (active),
        .phase_o    (phase),
        .period_o   (period),
        .load_o     (load),
        .shift_o    (shift)
    );

    bcs_tx_shift u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .shift  (shift),
        .word_i (tx_word),
        .msb_o  (msb)
    );

    // capture on the last reference cycle before the codec clock falls
    assign sample   = active && (phase == PH_W'(HALF_DIV - 1))
                   && (period >= PER_W'(WORD_W));
    assign last_per = (period == PER_W'(PERIODS - 1));

    bcs_rx_shift u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .last    (last_per),
        .bit_i   (rx_data),
        .word_o  (rx_word),
        .valid_o (rx_valid)
    );

    assign cdc_clk = active && (phase < PH_W'(HALF_DIV)) && loop_n;
    assign tx_en   = active && (period < PER_W'(WORD_W));
    assign rx_en   = !tx_en;
    assign tx_oe   = tx_en;
    assign tx_data = tx_en && msb;
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk (
    input logic clk,
    input logic rst_n,
    input logic loop_n,
    input logic cdc_clk,
    input logic tx_en,
    input logic rx_en,
    input logic rx_valid
);
    // R1
    reset_park_chk: assert property (@(posedge clk)
        !rst_n |=> (!cdc_clk && !tx_en && !rx_valid));

    // R2
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (cdc_clk || !loop_n));

    // R10
    loop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_n |-> !cdc_clk);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R4
    valid_in_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rx_en && !tx_en));
endmodule

bind burst_codec_clk bcs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .loop_n   (loop_n),
    .cdc_clk  (cdc_clk),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .rx_valid (rx_valid)
);

// File: tb/tb_burst_codec_clk.sv
`timescale 1ns/1ps
module tb_burst_codec_clk;
    logic       clk = 1'b0;
    logic       rst_n, burst_done, free_run, loop_n, rx_data;
    logic [7:0] tx_word;
    logic       cdc_clk, tx_en, rx_en, tx_data, tx_oe, rx_valid;
    logic [7:0] rx_word;

    int n_chk = 0;
    int n_fail = 0;
    int bad_c, bad_e, bad_t, bad_r;

    always #2.5 clk = ~clk;

    burst_codec_clk dut (
        .clk(clk), .rst_n(rst_n), .burst_done(burst_done), .free_run(free_run),
        .loop_n(loop_n), .tx_word(tx_word), .rx_data(rx_data),
        .cdc_clk(cdc_clk), .tx_en(tx_en), .rx_en(rx_en), .tx_data(tx_data),
        .tx_oe(tx_oe), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    // {loop_n, tx word, rx word}
    localparam logic [16:0] VECS [4] = '{
        {1'b1, 8'hA5, 8'h3C},
        {1'b1, 8'hFF, 8'h00},
        {1'b0, 8'h81, 8'h7E},
        {1'b1, 8'h00, 8'hFF}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clr_bad();
        bad_c = 0; bad_e = 0; bad_t = 0; bad_r = 0;
    endtask

    // expected outputs at train index rel, train length lim
    task automatic observe(input int rel, input int lim, input logic [7:0] txw,
                           input logic [7:0] rxw, input bit lp);
        bit in_b, e_clk, e_ten, e_td, e_rv;
        int kk, per, ph;
        in_b  = (rel >= 0) && (rel < lim);
        kk    = (rel < 0) ? 0 : rel % 512;
        per   = kk / 32;
        ph    = kk % 32;
        e_clk = in_b && (ph < 16) && lp;
        e_ten = in_b && (per < 8);
        e_td  = e_ten ? txw[7 - (per % 8)] : 1'b0;
        e_rv  = in_b && (kk == 496);
        if (cdc_clk !== e_clk) bad_c++;
        if (tx_en !== e_ten || tx_oe !== e_ten || rx_en !== !e_ten) bad_e++;
        if (tx_data !== e_td) bad_t++;
        if (rx_valid !== e_rv || (e_rv && rx_word !== rxw)) bad_r++;
    endtask

    task automatic drive_rx(input int rel, input logic [7:0] rxw);
        int per;
        per = (rel < 0) ? 0 : (rel % 512) / 32;
        rx_data = (rel >= 0 && per >= 8) ? rxw[15 - per] : 1'b0;
    endtask

    task automatic report(input string rq_clk, input string rq_en,
                          input string rq_tx, input string rq_rx);
        chk(bad_c == 0, rq_clk, "clock mismatches", bad_c, 0);
        chk(bad_e == 0, rq_en,  "enable mismatches", bad_e, 0);
        chk(bad_t == 0, rq_tx,  "tx data mismatches", bad_t, 0);
        chk(bad_r == 0, rq_rx,  "rx capture mismatches", bad_r, 0);
    endtask

    task automatic idle_check(input string req);
        chk(cdc_clk === 1'b0 && tx_en === 1'b0 && tx_oe === 1'b0 && rx_en === 1'b1,
            req, "idle outputs {clk,ten,oe,ren}", {cdc_clk, tx_en, tx_oe, rx_en}, 4'b0001);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; burst_done = 1'b0; free_run = 1'b0; loop_n = 1'b1;
        rx_data = 1'b0; tx_word = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        idle_check("R1");
        chk(rx_valid === 1'b0 && rx_word === 8'h00, "R1", "rx outputs",
            {rx_valid, rx_word}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // vector table: R2 R3 R4 R5 R6 R10
        foreach (VECS[i]) begin
            loop_n = VECS[i][16];
            tx_word = VECS[i][15:8];
            burst_done = 1'b1;
            @(negedge clk);
            burst_done = 1'b0;
            clr_bad();
            for (int k = 0; k < 530; k++) begin
                observe(k, 512, VECS[i][15:8], VECS[i][7:0], VECS[i][16]);
                drive_rx(k, VECS[i][7:0]);
                if (k == 3) tx_word = ~VECS[i][15:8];
                @(negedge clk);
            end
            report(VECS[i][16] ? "R2/R3" : "R10", "R4", "R5", "R6");
            idle_check("R3");
            loop_n = 1'b1;
        end

        // R7 retrigger mid-train
        tx_word = 8'hC3;
        burst_done = 1'b1;
        @(negedge clk);
        burst_done = 1'b0;
        clr_bad();
        for (int k = 0; k < 660; k++) begin
            if (k < 128) begin
                observe(k, 512, 8'hC3, 8'h5A, 1'b1);
                drive_rx(k, 8'h5A);
            end else begin
                observe(k - 128, 512, 8'h96, 8'h5A, 1'b1);
                drive_rx(k - 128, 8'h5A);
            end
            burst_done = (k == 100);
            if (k == 100) tx_word = 8'h96;
            @(negedge clk);
        end
        report("R7", "R7", "R7", "R7");

        // R8 free-run, then release
        tx_word = 8'h6D;
        free_run = 1'b1;
        @(negedge clk);
        clr_bad();
        for (int k = 0; k < 1560; k++) begin
            observe(k, 1536, 8'h6D, 8'hB1, 1'b1);
            drive_rx(k, 8'hB1);
            if (k == 1124) free_run = 1'b0;
            @(negedge clk);
        end
        report("R8", "R8", "R8", "R8");
        idle_check("R8");

        // R9 pulse during free-run suspends it
        tx_word = 8'h2E;
        free_run = 1'b1;
        @(negedge clk);
        clr_bad();
        for (int k = 0; k < 960; k++) begin
            if (k < 224) begin
                observe(k, 1 << 20, 8'h2E, 8'hE4, 1'b1);
                drive_rx(k, 8'hE4);
            end else begin
                observe(k - 224, 512, 8'h2E, 8'hE4, 1'b1);
                drive_rx(k - 224, 8'hE4);
            end
            burst_done = (k == 200);
            @(negedge clk);
        end
        report("R9", "R9", "R9", "R9");
        idle_check("R9");
        free_run = 1'b0;
        repeat (3) @(negedge clk);
        idle_check("R9");

        // R1 reset mid-train
        burst_done = 1'b1;
        @(negedge clk);
        burst_done = 1'b0;
        repeat (50) @(negedge clk);
        chk(tx_en === 1'b1, "R1", "train running before reset", tx_en, 1);
        rst_n = 1'b0;
        @(negedge clk);
        idle_check("R1");
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        idle_check("R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule